// File: doc/BRIEF.md
# Windowed Raster Timing Generator

This block produces the frame and line timing for a rectangular readout window placed inside a larger pixel array. The window is given as an even start column and start row, plus a width and a height written as size minus one. Two more inputs set the horizontal and vertical blanking lengths. Each cycle in which the pixel enable is high advances the raster by one pixel position. While a pixel of the window is active, the block reports that pixel's absolute array column and row. It also reports a two-bit colour code for the Bayer mosaic, taken from the parity of that column and row. Another block can use the coordinates to index a test pattern or an external frame memory.

The frame strobe is high while the window's lines are scanned, including the blanking gaps between lines. It drops only for vertical blanking. The line strobe is high only on active pixels. One clock after the last active pixel of a frame, a one-clock end-of-frame pulse appears.

The block latches all six geometry and blanking inputs at the start of each vertical blanking interval, so it never sees a partly applied change within a frame. Before the values are stored, bit 0 of each start is cleared and bit 0 of each size is set. The window therefore always starts on an even coordinate and has even dimensions.

Top module: `raster_window_gen`

## Requirements
- R1: While reset is asserted, and until the first enabled pixel tick after reset, frame_valid, line_valid and frame_end are low.
- R2: Each line holds exactly col_size+1 consecutive enabled ticks with line_valid high. Across those ticks, pix_col runs from col_start up by one per tick, and pix_row stays constant.
- R3: frame_valid is high whenever line_valid is high. It is also high during the horizontal blanking between lines of a frame, and low during vertical blanking.
- R4: A frame holds row_size+1 lines, with pix_row running from row_start up by one per line.
- R5: Horizontal blanking between two lines lasts h_blank+1 enabled ticks. Vertical blanking lasts v_blank+1 enabled ticks. The first tick after reset is the first tick of vertical blanking.
- R6: Bit 0 of col_start and of row_start is treated as 0, and bit 0 of col_size and of row_size is treated as 1.
- R7: While line_valid is high, bayer_tag equals {pix_row[0], pix_col[0]}: 2'b00 green on a red row, 2'b01 red, 2'b10 blue, 2'b11 green on a blue row.
- R8: All six geometry and blanking inputs are sampled only on the tick that starts vertical blanking. Changes at any other time act from the next frame onward.
- R9: In a cycle with pix_en low, frame_valid, line_valid, pix_col, pix_row and bayer_tag keep their values, and frame_end is low.
- R10: frame_end is high for exactly one clock, in the clock after the tick that ended the last active pixel of a frame. At no other time is it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| pix_en | input | 1 | Pixel tick enable; the raster advances one position per high cycle |
| col_start | input | COL_W | Window left column; bit 0 is ignored |
| row_start | input | ROW_W | Window top row; bit 0 is ignored |
| col_size | input | COL_W | Window width minus one; bit 0 is forced high |
| row_size | input | ROW_W | Window height minus one; bit 0 is forced high |
| h_blank | input | BLK_W | Horizontal blanking length minus one, in ticks |
| v_blank | input | BLK_W | Vertical blanking length minus one, in ticks |
| frame_valid | output | 1 | High during the window's lines and the gaps between them |
| line_valid | output | 1 | High on active pixels only |
| pix_col | output | COL_W | Absolute array column of the active pixel |
| pix_row | output | ROW_W | Absolute array row of the active pixel |
| bayer_tag | output | 2 | Colour code of the active pixel |
| frame_end | output | 1 | One-clock pulse after the last active pixel of a frame |

## Verification
A wrong state or counter shows at the ports as soon as the next pixel tick. It appears as a line of the wrong length, a blanking gap of the wrong length, or a strobe that is high during vertical blanking. A coordinate off by one shows on the next active pixel as a wrong column or wrong colour code. A geometry register that was latched at the wrong moment shows as a window of the wrong size or place, no later than the next active line.

// File: rtl/raster_pkg.sv
package raster_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_VBL  = 2'd1,
    ST_ACT  = 2'd2,
    ST_HBL  = 2'd3
  } raster_st_e;

  typedef enum logic [1:0] {
    TAG_GR = 2'b00,
    TAG_R  = 2'b01,
    TAG_B  = 2'b10,
    TAG_GB = 2'b11
  } bayer_tag_e;

endpackage

// File: rtl/raster_cfg_latch.sv
module raster_cfg_latch #(
  parameter int COL_W = 11,
  parameter int ROW_W = 11,
  parameter int BLK_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [COL_W-1:0] col_start,
  input  logic [ROW_W-1:0] row_start,
  input  logic [COL_W-1:0] col_size,
  input  logic [ROW_W-1:0] row_size,
  input  logic [BLK_W-1:0] h_blank,
  input  logic [BLK_W-1:0] v_blank,
  output logic [COL_W-1:0] cfg_c0,
  output logic [ROW_W-1:0] cfg_r0,
  output logic [COL_W-1:0] cfg_c1,
  output logic [ROW_W-1:0] cfg_r1,
  output logic [BLK_W-1:0] cfg_hb,
  output logic [BLK_W-1:0] cfg_vb
);

  logic [COL_W-1:0] c0_d, c1_d;
  logic [ROW_W-1:0] r0_d, r1_d;

  // Legalise the window, then precompute the last column and row
  always_comb begin
    c0_d = {col_start[COL_W-1:1], 1'b0};
    r0_d = {row_start[ROW_W-1:1], 1'b0};
    c1_d = c0_d + {col_size[COL_W-1:1], 1'b1};
    r1_d = r0_d + {row_size[ROW_W-1:1], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_c0 <= '0;
      cfg_r0 <= '0;
      cfg_c1 <= '0;
      cfg_r1 <= '0;
      cfg_hb <= '0;
      cfg_vb <= '0;
    end else if (load) begin
      cfg_c0 <= c0_d;
      cfg_r0 <= r0_d;
      cfg_c1 <= c1_d;
      cfg_r1 <= r1_d;
      cfg_hb <= h_blank;
      cfg_vb <= v_blank;
    end
  end

endmodule

// File: rtl/raster_seq.sv
module raster_seq
  import raster_pkg::*;
#(
  parameter int COL_W = 11,
  parameter int ROW_W = 11,
  parameter int BLK_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic [COL_W-1:0] cfg_c0,
  input  logic [ROW_W-1:0] cfg_r0,
  input  logic [COL_W-1:0] cfg_c1,
  input  logic [ROW_W-1:0] cfg_r1,
  input  logic [BLK_W-1:0] cfg_hb,
  input  logic [BLK_W-1:0] cfg_vb,
  output logic             load,
  output logic             fv,
  output logic             lv,
  output logic             eof,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row
);

  raster_st_e       st_q, st_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [BLK_W-1:0] bcnt_q, bcnt_d;
  logic             eof_q;
  logic             adv_load, adv_eof;

  // Next position, computed as if this cycle were a tick
  always_comb begin
    st_d     = st_q;
    col_d    = col_q;
    row_d    = row_q;
    bcnt_d   = bcnt_q;
    adv_load = 1'b0;
    adv_eof  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        st_d     = ST_VBL;
        bcnt_d   = '0;
        adv_load = 1'b1;
      end
      ST_VBL: begin
        if (bcnt_q == cfg_vb) begin
          st_d  = ST_ACT;
          col_d = cfg_c0;
          row_d = cfg_r0;
        end else begin
          bcnt_d = bcnt_q + 1'b1;
        end
      end
      ST_ACT: begin
        if (col_q == cfg_c1) begin
          bcnt_d = '0;
          if (row_q == cfg_r1) begin
            st_d     = ST_VBL;
            adv_load = 1'b1;
            adv_eof  = 1'b1;
          end else begin
            st_d = ST_HBL;
          end
        end else begin
          col_d = col_q + 1'b1;
        end
      end
      ST_HBL: begin
        if (bcnt_q == cfg_hb) begin
          st_d  = ST_ACT;
          col_d = cfg_c0;
          row_d = row_q + 1'b1;
        end else begin
          bcnt_d = bcnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign load = pix_en & adv_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      col_q  <= '0;
      row_q  <= '0;
      bcnt_q <= '0;
    end else if (pix_en) begin
      st_q   <= st_d;
      col_q  <= col_d;
      row_q  <= row_d;
      bcnt_q <= bcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eof_q <= 1'b0;
    else        eof_q <= pix_en & adv_eof;
  end

  assign fv  = (st_q == ST_ACT) || (st_q == ST_HBL);
  assign lv  = (st_q == ST_ACT);
  assign eof = eof_q;
  assign col = col_q;
  assign row = row_q;

  // R2
  line_start_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lv) |-> (col_q == cfg_c0));

  // R2
  window_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lv |-> (col_q >= cfg_c0) && (col_q <= cfg_c1));

  // R4
  window_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lv |-> (row_q >= cfg_r0) && (row_q <= cfg_r1));

  // R10
  eof_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_q |-> (!lv && $past(lv)));

  // R9
  hold_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(col_q) && $stable(row_q) && $stable(st_q) && !eof_q));

endmodule

// File: rtl/raster_bayer.sv
module raster_bayer
  import raster_pkg::*;
(
  input  logic       col_lsb,
  input  logic       row_lsb,
  output logic [1:0] tag
);

  bayer_tag_e tag_e;

  always_comb begin
    unique case ({row_lsb, col_lsb})
      2'b00:   tag_e = TAG_GR;
      2'b01:   tag_e = TAG_R;
      2'b10:   tag_e = TAG_B;
      default: tag_e = TAG_GB;
    endcase
  end

  assign tag = tag_e;

endmodule

// File: rtl/raster_window_gen.sv
module raster_window_gen #(
  parameter int COL_W = 11,
  parameter int ROW_W = 11,
  parameter int BLK_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic [COL_W-1:0] col_start,
  input  logic [ROW_W-1:0] row_start,
  input  logic [COL_W-1:0] col_size,
  input  logic [ROW_W-1:0] row_size,
  input  logic [BLK_W-1:0] h_blank,
  input  logic [BLK_W-1:0] v_blank,
  output logic             frame_valid,
  output logic             line_valid,
  output logic [COL_W-1:0] pix_col,
  output logic [ROW_W-1:0] pix_row,
  output logic [1:0]       bayer_tag,
  output logic             frame_end
);

  logic             rst_meta_n, rst_sync_n;
  logic             load;
  logic [COL_W-1:0] cfg_c0, cfg_c1;
  logic [ROW_W-1:0] cfg_r0, cfg_r1;
  logic [BLK_W-1:0] cfg_hb, cfg_vb;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  raster_cfg_latch #(.COL_W(COL_W), .ROW_W(ROW_W), .BLK_W(BLK_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (load),
    .col_start (col_start),
    .row_start (row_start),
    .col_size  (col_size),
    .row_size  (row_size),
    .h_blank   (h_blank),
    .v_blank   (v_blank),
    .cfg_c0    (cfg_c0),
    .cfg_r0    (cfg_r0),
    .cfg_c1    (cfg_c1),
    .cfg_r1    (cfg_r1),
    .cfg_hb    (cfg_hb),
    .cfg_vb    (cfg_vb)
  );

  raster_seq #(.COL_W(COL_W), .ROW_W(ROW_W), .BLK_W(BLK_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pix_en (pix_en),
    .cfg_c0 (cfg_c0),
    .cfg_r0 (cfg_r0),
    .cfg_c1 (cfg_c1),
    .cfg_r1 (cfg_r1),
    .cfg_hb (cfg_hb),
    .cfg_vb (cfg_vb),
    .load   (load),
    .fv     (frame_valid),
    .lv     (line_valid),
    .eof    (frame_end),
    .col    (pix_col),
    .row    (pix_row)
  );

  raster_bayer u_bayer (
    .col_lsb (pix_col[0]),
    .row_lsb (pix_row[0]),
    .tag     (bayer_tag)
  );

  // R3
  lv_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    line_valid |-> frame_valid);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_valid |-> ($stable(cfg_c0) && $stable(cfg_c1) && $stable(cfg_r0) &&
                     $stable(cfg_r1) && $stable(cfg_hb) && $stable(cfg_vb)));

  // R6
  even_origin_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(frame_valid) |-> (pix_col[0] == 1'b0 && pix_row[0] == 1'b0));

endmodule

// File: tb/raster_window_gen_tb.sv
module raster_window_gen_tb;

  localparam int CLK_P = 10;
  localparam int WD_CYCLES = 20000;

  logic        clk;
  logic        rst_n;
  logic        pix_en;
  logic [10:0] i_cs, i_rs, i_cw, i_rh;
  logic [11:0] i_hb, i_vb;
  logic        fv, lv, eof;
  logic [10:0] pcol, prow;
  logic [1:0]  tag;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string ctx = "R1";

  // bench model
  bit started;
  int q, m_cs, m_rs, m_w, m_h, m_hb, m_vb;
  bit e_eof;

  raster_window_gen u_dut (
    .clk (clk), .rst_n (rst_n), .pix_en (pix_en),
    .col_start (i_cs), .row_start (i_rs), .col_size (i_cw), .row_size (i_rh),
    .h_blank (i_hb), .v_blank (i_vb),
    .frame_valid (fv), .line_valid (lv), .pix_col (pcol), .pix_row (prow),
    .bayer_tag (tag), .frame_end (eof)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic sample_cfg();
    m_cs = int'(i_cs) & ~1;
    m_rs = int'(i_rs) & ~1;
    m_w  = (int'(i_cw) | 1) + 1;
    m_h  = (int'(i_rh) | 1) + 1;
    m_hb = int'(i_hb) + 1;
    m_vb = int'(i_vb) + 1;
  endtask

  function automatic int period();
    return m_vb + m_h * m_w + (m_h - 1) * m_hb;
  endfunction

  task automatic model_tick(input bit en);
    e_eof = 1'b0;
    if (!en) return;
    if (!started) begin
      started = 1'b1;
      q = 0;
      sample_cfg();
    end else begin
      q++;
      if (q == period()) begin
        q = 0;
        e_eof = 1'b1;
        sample_cfg();
      end
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s %s actual %0d expected %0d", ctx, req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit efv, elv;
    int ecol, erow, rr, li, c;
    efv = 0; elv = 0; ecol = 0; erow = 0;
    if (started && q >= m_vb) begin
      rr = q - m_vb;
      li = rr / (m_w + m_hb);
      c  = rr % (m_w + m_hb);
      efv = 1;
      if (c < m_w) begin
        elv = 1; ecol = m_cs + c; erow = m_rs + li;
      end
    end
    chk("R3", "frame_valid", int'(fv), int'(efv));
    chk("R2", "line_valid", int'(lv), int'(elv));
    chk("R10", "frame_end", int'(eof), int'(e_eof));
    if (elv && lv) begin
      chk("R2", "pix_col", int'(pcol), ecol);
      chk("R4", "pix_row", int'(prow), erow);
      chk("R7", "bayer_tag", int'(tag), ((erow & 1) << 1) | (ecol & 1));
    end
  endtask

  task automatic cycle(input bit en);
    pix_en = en;
    @(posedge clk);
    #(CLK_P/4);
    model_tick(en);
    compare();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pix_en = 1'b0;
    started = 1'b0;
    q = 0;
    e_eof = 1'b0;
    repeat (3) @(negedge clk);
    ctx = "R1";
    chk("R1", "frame_valid in reset", int'(fv), 0);
    chk("R1", "line_valid in reset", int'(lv), 0);
    chk("R1", "frame_end in reset", int'(eof), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cycle(1'b0);
  endtask

  task automatic set_cfg(input int cs, input int rs, input int cw, input int rh,
                         input int hb, input int vb);
    i_cs = cs[10:0]; i_rs = rs[10:0]; i_cw = cw[10:0]; i_rh = rh[10:0];
    i_hb = hb[11:0]; i_vb = vb[11:0];
  endtask

  initial begin
    rst_n = 1'b0;
    pix_en = 1'b0;
    set_cfg(4, 6, 5, 3, 2, 3);
    @(negedge clk);

    // R5: legal window, continuous ticks, three frames
    do_reset();
    ctx = "R5";
    for (int i = 0; i < 120; i++) cycle(1'b1);

    // R6 and R9: odd starts, even sizes, zero blanking, gated ticks
    set_cfg(7, 9, 4, 2, 0, 0);
    do_reset();
    ctx = "R6_R9";
    for (int i = 0; i < 180; i++) cycle(i % 3 != 2);

    // R8: inputs change in the middle of a frame
    set_cfg(2, 2, 3, 1, 1, 1);
    do_reset();
    ctx = "R8";
    for (int i = 0; i < 7; i++) cycle(1'b1);
    set_cfg(10, 20, 7, 5, 3, 2);
    for (int i = 0; i < 12; i++) cycle(1'b1);
    set_cfg(30, 41, 2, 0, 0, 4);
    for (int i = 0; i < 250; i++) cycle(i % 5 != 0);

    // R7: start in an odd-aligned area of the array
    set_cfg(1023, 513, 9, 3, 1, 0);
    do_reset();
    ctx = "R7";
    for (int i = 0; i < 160; i++) cycle(1'b1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule